// File: doc/BRIEF.md
# Burst Request Legality and Regularity Checker

This block inspects one memory-bus burst request (start address, size code, length code, burst code) and reports every rule the request breaks, each on its own bit. It also says whether the request belongs to the restricted regular subset, which simpler subordinates and bridges can rely on. Data beats and byte strobes are never examined. All checks apply to the byte container that the request describes, not to the bytes that end up being written.

The request is sampled on a clock edge when its valid strobe is high. The verdict appears on registered outputs one cycle later. The bus data width, page size and address width are parameters.

Top module: `reqchk_top`

## Requirements
- R1: After a clock edge that samples `req_valid` high, `chk_valid` is high for that cycle. After an edge that samples it low, `chk_valid` is low and `chk_viol` and `chk_regular` are zero. All three outputs are zero in reset.
- R2: Bit 0 of `chk_viol` is set when the size code (bytes per beat = 2^code) is larger than log2 of the data bus width in bytes.
- R3: Bit 1 is set for burst code 3, which is reserved. Bit 5 (page) is never set for such a request. Burst codes are 0 FIXED, 1 INCR, 2 WRAP.
- R4: Bit 2 is set for a WRAP request whose beat count (length code + 1) is not 2, 4, 8 or 16.
- R5: Bit 3 is set for a WRAP request whose start address is not a multiple of the beat size.
- R6: Bit 4 is set for a FIXED request of more than 16 beats.
- R7: Bit 5 is set when the container crosses a page boundary, that is, when its lowest and highest byte differ in any address bit at or above log2(page size). Running past the top of the address space also counts as a crossing. The INCR container starts at the start address rounded down to the beat size and spans beats × beat size. The FIXED container is a single beat. Example with a 4 KB page: start 0x0FF0, 4-byte beats, 4 beats is legal, and 5 beats is flagged.
- R8: For a WRAP request of legal length, the page test uses the wrap container: the start address rounded down to beats × beat size, spanning that many bytes. A WRAP request of illegal length is tested like INCR.
- R9: `chk_regular` is high only when all of the following hold: the beat count is 1, 2, 4, 8 or 16; a request of more than one beat uses the full bus width; the burst is INCR or WRAP; an INCR start is a multiple of beats × beat size; a WRAP start is a multiple of the beat size.
- R10: `chk_regular` is low whenever any bit of `chk_viol` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 3 | Beat size code, bytes = 2^code |
| req_len | input | 8 | Beat count minus one |
| req_burst | input | 2 | 0 FIXED, 1 INCR, 2 WRAP, 3 reserved |
| chk_valid | output | 1 | Verdict valid |
| chk_viol | output | 6 | Violation bits: 0 size, 1 reserved burst, 2 wrap length, 3 wrap alignment, 4 fixed length, 5 page crossing |
| chk_regular | output | 1 | Request is in the regular subset |

## Verification
The page test is tried with INCR requests that end exactly on the boundary and one beat past it. It is also tried with a request that wraps past the top of the address space. A WRAP request whose start-relative span would cross the boundary, but whose wrap container does not, separates R8 from a naive start-plus-length test. A FIXED request that ends at a page edge confirms that FIXED uses a single-beat container. Regularity is tried with aligned and unaligned INCR, narrow single beats, narrow multi-beat and FIXED requests, and a legal-looking oversize single beat that only the size bit disqualifies. Back-to-back and idle cycles separate per-request results from stale ones.

// File: rtl/reqchk_pkg.sv
package reqchk_pkg;
   localparam int SIZE_W          = 3;
   localparam int LEN_W           = 8;
   localparam int TOT_W           = LEN_W + (1 << SIZE_W);
   localparam int REG_MAX_LG      = 4;
   localparam int FIXED_MAX_BEATS = 16;

   localparam int V_SIZE   = 0;
   localparam int V_RSVD   = 1;
   localparam int V_WLEN   = 2;
   localparam int V_WALIGN = 3;
   localparam int V_FLEN   = 4;
   localparam int V_PAGE   = 5;
   localparam int NVIOL    = 6;

   typedef enum logic [1:0] {
      BURST_FIXED = 2'd0,
      BURST_INCR  = 2'd1,
      BURST_WRAP  = 2'd2,
      BURST_RSVD  = 2'd3
   } burst_e;
endpackage

// File: rtl/reqchk_shape.sv
module reqchk_shape
   import reqchk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   input  logic [LEN_W-1:0]  len,
   output logic [TOT_W-1:0]  beat_bytes,
   output logic [TOT_W-1:0]  total_bytes,
   output logic              len_pow2,
   output logic              size_unaligned,
   output logic              cont_aligned
);
   localparam int NPOW = REG_MAX_LG + 1;

   logic [LEN_W:0]      beats;
   logic [NPOW-1:0]     pow_hit;
   logic [ADDR_W-1:0]   size_mask;
   logic [ADDR_W-1:0]   tot_mask;

   for (genvar k = 0; k < NPOW; k++) begin : g_pow
      assign pow_hit[k] = (len == LEN_W'((1 << k) - 1));
   end

   assign len_pow2    = |pow_hit;
   assign beats       = {1'b0, len} + (LEN_W+1)'(1);
   assign beat_bytes  = TOT_W'(1) << size;
   assign total_bytes = TOT_W'(beats) << size;

   assign size_mask      = ADDR_W'(beat_bytes - TOT_W'(1));
   assign tot_mask       = ADDR_W'(total_bytes - TOT_W'(1));
   assign size_unaligned = |(addr & size_mask);
   assign cont_aligned   = len_pow2 && ((addr & tot_mask) == '0);
endmodule

// File: rtl/reqchk_page.sv
module reqchk_page
   import reqchk_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PAGE_LSB = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  burst_e            burst,
   input  logic [TOT_W-1:0]  beat_bytes,
   input  logic [TOT_W-1:0]  total_bytes,
   input  logic              wrap_len_ok,
   output logic              page_cross
);
   localparam int AW1 = ADDR_W + 1;

   logic [AW1-1:0]    lo;
   logic [AW1-1:0]    hi;
   logic [TOT_W-1:0]  span;
   logic [ADDR_W-1:0] base;
   logic              cross_raw;

   always_comb begin
      span = total_bytes;
      base = addr & ~ADDR_W'(beat_bytes - TOT_W'(1));
      unique case (burst)
         BURST_FIXED: span = beat_bytes;
         BURST_WRAP: begin
            if (wrap_len_ok) base = addr & ~ADDR_W'(total_bytes - TOT_W'(1));
         end
         default: span = total_bytes;
      endcase
      lo = {1'b0, base};
      hi = lo + AW1'(span) - AW1'(1);
   end

   if (PAGE_LSB < ADDR_W) begin : g_paged
      assign cross_raw = (hi[ADDR_W:PAGE_LSB] != lo[ADDR_W:PAGE_LSB]);
   end else begin : g_flat
      assign cross_raw = hi[ADDR_W];
   end

   assign page_cross = (burst != BURST_RSVD) && cross_raw;
endmodule

// File: rtl/reqchk_rules.sv
module reqchk_rules
   import reqchk_pkg::*;
#(
   parameter int SIZE_MAX = 3
) (
   input  logic [SIZE_W-1:0] size,
   input  logic [LEN_W-1:0]  len,
   input  burst_e            burst,
   input  logic              len_pow2,
   input  logic              size_unaligned,
   input  logic              cont_aligned,
   input  logic              page_cross,
   output logic [NVIOL-1:0]  viol,
   output logic              regular
);
   logic shape_ok;
   logic width_ok;

   always_comb begin
      viol           = '0;
      viol[V_SIZE]   = size > SIZE_W'(SIZE_MAX);
      viol[V_RSVD]   = (burst == BURST_RSVD);
      viol[V_WLEN]   = (burst == BURST_WRAP) && !(len_pow2 && len != '0);
      viol[V_WALIGN] = (burst == BURST_WRAP) && size_unaligned;
      viol[V_FLEN]   = (burst == BURST_FIXED) && (len >= LEN_W'(FIXED_MAX_BEATS));
      viol[V_PAGE]   = page_cross;
   end

   always_comb begin
      unique case (burst)
         BURST_INCR: shape_ok = cont_aligned;
         BURST_WRAP: shape_ok = !size_unaligned;
         default:    shape_ok = 1'b0;
      endcase
   end

   assign width_ok = (len == '0) || (size == SIZE_W'(SIZE_MAX));
   assign regular  = !(|viol) && len_pow2 && width_ok && shape_ok;
endmodule

// File: rtl/reqchk_top.sv
module reqchk_top
   import reqchk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_BYTES = 8,
   parameter int PAGE_BYTES = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic [7:0]        req_len,
   input  logic [1:0]        req_burst,
   output logic              chk_valid,
   output logic [5:0]        chk_viol,
   output logic              chk_regular
);
   localparam int SIZE_MAX = $clog2(DATA_BYTES);
   localparam int PAGE_LSB = $clog2(PAGE_BYTES);

   if (DATA_BYTES < 1 || DATA_BYTES > 128 || (DATA_BYTES & (DATA_BYTES - 1)) != 0) begin : g_bad_data
      $error("DATA_BYTES must be a power of two from 1 to 128");
   end
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (ADDR_W < TOT_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the largest container");
   end

   burst_e             burst;
   logic [TOT_W-1:0]   beat_bytes;
   logic [TOT_W-1:0]   total_bytes;
   logic               len_pow2;
   logic               size_unaligned;
   logic               cont_aligned;
   logic               page_cross;
   logic [NVIOL-1:0]   viol_c;
   logic               regular_c;

   assign burst = burst_e'(req_burst);

   reqchk_shape #(.ADDR_W(ADDR_W)) u_shape (
      .addr           (req_addr),
      .size           (req_size),
      .len            (req_len),
      .beat_bytes     (beat_bytes),
      .total_bytes    (total_bytes),
      .len_pow2       (len_pow2),
      .size_unaligned (size_unaligned),
      .cont_aligned   (cont_aligned)
   );

   reqchk_page #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_page (
      .addr        (req_addr),
      .burst       (burst),
      .beat_bytes  (beat_bytes),
      .total_bytes (total_bytes),
      .wrap_len_ok (len_pow2 && req_len != '0),
      .page_cross  (page_cross)
   );

   reqchk_rules #(.SIZE_MAX(SIZE_MAX)) u_rules (
      .size           (req_size),
      .len            (req_len),
      .burst          (burst),
      .len_pow2       (len_pow2),
      .size_unaligned (size_unaligned),
      .cont_aligned   (cont_aligned),
      .page_cross     (page_cross),
      .viol           (viol_c),
      .regular        (regular_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_valid   <= 1'b0;
         chk_viol    <= '0;
         chk_regular <= 1'b0;
      end else begin
         chk_valid   <= req_valid;
         chk_viol    <= req_valid ? viol_c : '0;
         chk_regular <= req_valid && regular_c;
      end
   end

   // R1 latency and idle behaviour
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> chk_valid);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!chk_valid && chk_viol == '0 && !chk_regular));
   // R2 oversize beat
   p_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size > 3'(SIZE_MAX)) |=> chk_viol[V_SIZE]);
   // R3 reserved burst flagged, page test skipped
   p_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_burst == 2'd3) |=> (chk_viol[V_RSVD] && !chk_viol[V_PAGE]));
   // R6 FIXED length limit
   p_fixed_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_burst == 2'd0 && req_len >= 8'd16) |=> chk_viol[V_FLEN]);
   // R9 FIXED never regular
   p_fixed_irregular_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_burst == 2'd0) |=> !chk_regular);
   // R10 regular excluded by any violation
   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && (|chk_viol)) |-> !chk_regular);
endmodule

// File: tb/tb_reqchk_top.sv
module tb_reqchk_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [7:0]  req_len = '0;
   logic [1:0]  req_burst = '0;
   logic        chk_valid;
   logic [5:0]  chk_viol;
   logic        chk_regular;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   reqchk_top dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_len(req_len), .req_burst(req_burst),
      .chk_valid(chk_valid), .chk_viol(chk_viol), .chk_regular(chk_regular)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(logic [31:0] a, logic [2:0] s, logic [7:0] l, logic [1:0] b);
      req_addr = a; req_size = s; req_len = l; req_burst = b; req_valid = 1'b1;
   endtask

   task automatic expect_out(string tag, logic [5:0] ev, logic er);
      chk({tag, " valid"}, 32'(chk_valid), 32'd1);
      chk({tag, " viol"}, 32'(chk_viol), 32'(ev));
      chk({tag, " regular"}, 32'(chk_regular), 32'(er));
   endtask

   task automatic try_req(string tag, logic [31:0] a, logic [2:0] s, logic [7:0] l,
                          logic [1:0] b, logic [5:0] ev, logic er);
      @(negedge clk);
      drive(a, s, l, b);
      @(negedge clk);
      req_valid = 1'b0;
      expect_out(tag, ev, er);
   endtask

   task automatic t_reset();
      chk("R1 reset valid", 32'(chk_valid), 0);
      chk("R1 reset viol", 32'(chk_viol), 0);
      chk("R1 reset regular", 32'(chk_regular), 0);
   endtask

   task automatic t_page_incr();
      try_req("R7 incr ends on boundary", 32'h0FF0, 3'd2, 8'd3, 2'd1, 6'h00, 1'b0);
      try_req("R7 incr one beat past", 32'h0FF0, 3'd2, 8'd4, 2'd1, 6'h20, 1'b0);
      try_req("R7 top of address space", 32'hFFFF_FFF8, 3'd3, 8'd1, 2'd1, 6'h20, 1'b0);
      try_req("R7 fixed single-beat container", 32'h0FFC, 3'd2, 8'd15, 2'd0, 6'h00, 1'b0);
   endtask

   task automatic t_page_wrap();
      try_req("R8 wrap container stays in page", 32'h0FF8, 3'd3, 8'd3, 2'd2, 6'h00, 1'b1);
      try_req("R8 wrap 16 beats", 32'h00F8, 3'd3, 8'd15, 2'd2, 6'h00, 1'b1);
   endtask

   task automatic t_size();
      try_req("R2 R10 oversize single beat", 32'h0, 3'd4, 8'd0, 2'd1, 6'h01, 1'b0);
   endtask

   task automatic t_rsvd();
      try_req("R3 reserved burst no page bit", 32'h0FFF, 3'd0, 8'd255, 2'd3, 6'h02, 1'b0);
   endtask

   task automatic t_wrap_rules();
      try_req("R4 wrap three beats", 32'h0100, 3'd3, 8'd2, 2'd2, 6'h04, 1'b0);
      try_req("R5 wrap misaligned", 32'h0104, 3'd3, 8'd1, 2'd2, 6'h08, 1'b0);
   endtask

   task automatic t_fixed_len();
      try_req("R6 fixed 17 beats", 32'h0, 3'd3, 8'd16, 2'd0, 6'h10, 1'b0);
   endtask

   task automatic t_regular();
      try_req("R9 aligned full-width incr", 32'h1000, 3'd3, 8'd3, 2'd1, 6'h00, 1'b1);
      try_req("R9 incr not container aligned", 32'h1008, 3'd3, 8'd3, 2'd1, 6'h00, 1'b0);
      try_req("R9 narrow single beat", 32'h0005, 3'd0, 8'd0, 2'd1, 6'h00, 1'b1);
      try_req("R9 unaligned single beat", 32'h0003, 3'd3, 8'd0, 2'd1, 6'h00, 1'b0);
      try_req("R9 narrow multi-beat", 32'h0000, 3'd2, 8'd1, 2'd1, 6'h00, 1'b0);
      try_req("R9 three beats incr", 32'h0000, 3'd3, 8'd2, 2'd1, 6'h00, 1'b0);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      drive(32'h0FF0, 3'd2, 8'd4, 2'd1);
      @(negedge clk);
      drive(32'h2000, 3'd3, 8'd7, 2'd1);
      expect_out("R1 first of pair", 6'h20, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      expect_out("R1 second of pair", 6'h00, 1'b1);
      @(negedge clk);
      chk("R1 idle valid", 32'(chk_valid), 0);
      chk("R1 idle viol", 32'(chk_viol), 0);
      chk("R1 idle regular", 32'(chk_regular), 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_page_incr();
      t_page_wrap();
      t_size();
      t_rsvd();
      t_wrap_rules();
      t_fixed_len();
      t_regular();
      t_back_to_back();
      done = 1;
      finish_run();
   end
endmodule